// File: doc/BRIEF.md
# Region Coherence Tracking Array

This block sits beside a processor's line cache and keeps a coarse view of sharing for large aligned regions of memory. A region is a power-of-two group of consecutive cache lines. For each miss that leaves the processor, the block picks one of three routes: complete the operation locally with no external request, send it straight to the memory controller, or broadcast it to all other processors. The region lookup runs alongside the line-cache tag lookup, so the line-hit result arrives on the same cycle as the request.

The block learns what other nodes hold from the combined snoop response of its own broadcasts. That response arrives on a fill port and creates or updates a region entry. When another processor's request is snooped, the block probes its array. It returns whether this node still caches lines of the region, and it weakens its own view of the region so that later local misses are broadcast again. A per-entry count of locally cached lines, driven by line fill and line eviction events, keeps an entry from being replaced while it still protects cached lines.

The array is set-associative with least-recently-used replacement. All outputs are registered one cycle after the input that causes them.

Top module: `rgn_track_array`

## Requirements
- R1: The region number is the line address shifted right by log2(LINES_PER_RGN). Its low log2(SETS) bits select the set and the rest form the tag. All lines of a region share one entry, and a different region is unaffected by that entry.
- R2: `route_valid` is high exactly one cycle after `lreq_valid`. `route_code` then reads 0 = complete locally, 1 = direct to memory, 2 = broadcast. The value 3 never appears.
- R3: A write-back (kind 4) is always routed direct (1), whatever the region state and line-hit input.
- R4: Any other kind with `lreq_line_hit` high is routed local (0).
- R5: A line miss to a region with no entry is routed broadcast (2), for every kind except write-back.
- R6: A fill with `fill_remote` = 0 (no remote copies) puts the region in the exclusive state. Read (0), write (1), prefetch (2) and instruction-fetch (3) misses to it are then routed direct.
- R7: An upgrade (5) or cache-block operation (6) that misses to an exclusive region is routed local.
- R8: A fill with `fill_remote` = 1 (remote copies clean only) routes instruction-fetch misses direct and all other non-write-back misses broadcast. A fill with `fill_remote` = 2 or 3 (remote copies possibly modified) routes all non-write-back misses broadcast.
- R9: A snoop with `snp_excl` = 0 turns an exclusive region into the clean-remote state. A snoop with `snp_excl` = 1 turns an exclusive or clean-remote region into the dirty-remote state. A snoop to an absent region creates nothing.
- R10: `snp_resp_valid` is high exactly one cycle after `snp_valid`. `snp_resp_cached` is then 1 only if the region has an entry whose local line count is nonzero.
- R11: The line count of an entry rises by one on `lfill_valid` and falls by one on `levict_valid` for a line in that region. It saturates at LINES_PER_RGN and at 0. Line events for a region with no entry are not counted.
- R12: A fill that misses allocates into the first invalid way of the set. If there is none, it takes the least recently used way whose line count is zero. If every way has a nonzero count, nothing is allocated. A fill and a local request that hits both mark their way most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local request present |
| lreq_line | input | LINE_AW | Line address of the local request |
| lreq_kind | input | 3 | 0 read, 1 write, 2 prefetch, 3 instruction fetch, 4 write-back, 5 upgrade, 6 cache-block operation |
| lreq_line_hit | input | 1 | Same-cycle line-cache hit result |
| route_valid | output | 1 | Route decision present |
| route_code | output | 2 | 0 local, 1 direct to memory, 2 broadcast |
| snp_valid | input | 1 | Snoop from another processor |
| snp_line | input | LINE_AW | Snooped line address |
| snp_excl | input | 1 | Snooper wants a modifiable copy |
| snp_resp_valid | output | 1 | Region status for the snoop response |
| snp_resp_cached | output | 1 | This node caches lines of the snooped region |
| fill_valid | input | 1 | Combined snoop response of a local broadcast |
| fill_line | input | LINE_AW | Line address of that broadcast |
| fill_remote | input | 2 | 0 none remote, 1 clean remote, 2 or 3 possibly modified remote |
| lfill_valid | input | 1 | A line was filled into the local cache |
| lfill_line | input | LINE_AW | Address of the filled line |
| levict_valid | input | 1 | A line was evicted from the local cache |
| levict_line | input | LINE_AW | Address of the evicted line |

## Verification
The hardest situation to reach is a fill miss in a full set where the least recently used way still protects cached lines. The bench fills two regions into one set, adds a line to the older one, and touches the younger one with a hit. The next fill to a third region in that set must then pass over the LRU way and replace the other. Which entry survived is read back only through the routes of later requests. The routing table is swept over every kind, line-hit value and line offset in each of the four region states. Snoop downgrades are swept over every starting state and both snoop types.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

   typedef enum logic [1:0] {
      RS_INV    = 2'd0,
      RS_EXCL   = 2'd1,
      RS_RCLEAN = 2'd2,
      RS_RDIRTY = 2'd3
   } rstate_e;

   typedef enum logic [2:0] {
      K_READ   = 3'd0,
      K_WRITE  = 3'd1,
      K_PREF   = 3'd2,
      K_IFETCH = 3'd3,
      K_WBACK  = 3'd4,
      K_UPGR   = 3'd5,
      K_CBOP   = 3'd6
   } kind_e;

   typedef enum logic [1:0] {
      RT_LOCAL  = 2'd0,
      RT_DIRECT = 2'd1,
      RT_BCAST  = 2'd2
   } route_e;

   // State learned from the combined response of a local broadcast.
   function automatic rstate_e state_from_resp(input logic [1:0] remote);
      case (remote)
         2'd0:    return RS_EXCL;
         2'd1:    return RS_RCLEAN;
         default: return RS_RDIRTY;
      endcase
   endfunction

   // Weakening of the local view when another node touches the region.
   function automatic rstate_e state_after_snoop(input rstate_e cur, input logic excl);
      case (cur)
         RS_EXCL:   return excl ? RS_RDIRTY : RS_RCLEAN;
         RS_RCLEAN: return excl ? RS_RDIRTY : RS_RCLEAN;
         default:   return cur;
      endcase
   endfunction

endpackage

// File: rtl/rgn_probe.sv
module rgn_probe #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_vld,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           way
);

   always_comb begin
      hit = 1'b0;
      way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_vld[w] && (way_tag[w] == tag) && !hit) begin
            hit = 1'b1;
            way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/rgn_victim_pick.sv
module rgn_victim_pick #(
   parameter int WAYS  = 4,
   parameter int CNT_W = 5,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]            way_vld,
   input  logic [WAYS-1:0][CNT_W-1:0] way_cnt,
   input  logic [WAYS-1:0][WAY_W-1:0] way_age,
   output logic                       found,
   output logic [WAY_W-1:0]           way
);

   logic             have_inv;
   logic [WAY_W-1:0] best_age;

   always_comb begin
      found    = 1'b0;
      have_inv = 1'b0;
      way      = '0;
      best_age = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!way_vld[w] && !have_inv) begin
            have_inv = 1'b1;
            found    = 1'b1;
            way      = WAY_W'(w);
         end
      end
      if (!have_inv) begin
         for (int w = 0; w < WAYS; w++) begin
            if ((way_cnt[w] == '0) && (!found || (way_age[w] > best_age))) begin
               found    = 1'b1;
               way      = WAY_W'(w);
               best_age = way_age[w];
            end
         end
      end
   end

endmodule

// File: rtl/rgn_route_decide.sv
module rgn_route_decide
   import rgn_pkg::*;
(
   input  logic [2:0] kind,
   input  logic       line_hit,
   input  logic [1:0] rstate,
   output logic [1:0] route
);

   always_comb begin
      if (kind == K_WBACK) begin
         route = RT_DIRECT;
      end else if (line_hit) begin
         route = RT_LOCAL;
      end else begin
         case (rstate)
            RS_EXCL:   route = ((kind == K_UPGR) || (kind == K_CBOP)) ? RT_LOCAL : RT_DIRECT;
            RS_RCLEAN: route = (kind == K_IFETCH) ? RT_DIRECT : RT_BCAST;
            default:   route = RT_BCAST;
         endcase
      end
   end

endmodule

// File: rtl/rgn_track_array.sv
module rgn_track_array
   import rgn_pkg::*;
#(
   parameter int LINE_AW       = 20,
   parameter int LINES_PER_RGN = 16,
   parameter int SETS          = 16,
   parameter int WAYS          = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lreq_valid,
   input  logic [LINE_AW-1:0] lreq_line,
   input  logic [2:0]         lreq_kind,
   input  logic               lreq_line_hit,
   output logic               route_valid,
   output logic [1:0]         route_code,
   input  logic               snp_valid,
   input  logic [LINE_AW-1:0] snp_line,
   input  logic               snp_excl,
   output logic               snp_resp_valid,
   output logic               snp_resp_cached,
   input  logic               fill_valid,
   input  logic [LINE_AW-1:0] fill_line,
   input  logic [1:0]         fill_remote,
   input  logic               lfill_valid,
   input  logic [LINE_AW-1:0] lfill_line,
   input  logic               levict_valid,
   input  logic [LINE_AW-1:0] levict_line
);

   localparam int OFF_W  = $clog2(LINES_PER_RGN);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = LINE_AW - OFF_W - SET_W;
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int CNT_W  = $clog2(LINES_PER_RGN + 1);
   localparam int NPROBE = 5;
   // probe slots
   localparam int P_REQ = 0;
   localparam int P_SNP = 1;
   localparam int P_FIL = 2;
   localparam int P_LFL = 3;
   localparam int P_LEV = 4;

   generate
      if ((LINES_PER_RGN < 2) || ((LINES_PER_RGN & (LINES_PER_RGN - 1)) != 0))
         $error("LINES_PER_RGN must be a power of two of at least 2");
      if ((SETS < 2) || ((SETS & (SETS - 1)) != 0))
         $error("SETS must be a power of two of at least 2");
      if (WAYS < 1)
         $error("WAYS must be at least 1");
      if (TAG_W < 1)
         $error("LINE_AW too small for the region and set fields");
   endgenerate

   // ---------------- storage ----------------
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0][1:0]       st_q;
   logic [SETS-1:0][WAYS-1:0][CNT_W-1:0] cnt_q;
   logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

   // ---------------- probes ----------------
   logic [NPROBE-1:0][LINE_AW-1:0] pr_line;
   logic [NPROBE-1:0][SET_W-1:0]   pr_set;
   logic [NPROBE-1:0][TAG_W-1:0]   pr_tag;
   logic [NPROBE-1:0][WAYS-1:0]    pr_vld;
   logic [NPROBE-1:0]             pr_hit;
   logic [NPROBE-1:0][WAY_W-1:0]   pr_way;
   logic [NPROBE-1:0][OFF_W-1:0]   pr_off;
   logic                          unused_offset_bits;

   assign pr_line[P_REQ] = lreq_line;
   assign pr_line[P_SNP] = snp_line;
   assign pr_line[P_FIL] = fill_line;
   assign pr_line[P_LFL] = lfill_line;
   assign pr_line[P_LEV] = levict_line;

   genvar gp, gw, gs;
   generate
      for (gp = 0; gp < NPROBE; gp++) begin : g_probe
         assign pr_off[gp] = pr_line[gp][OFF_W-1:0];
         assign pr_set[gp] = pr_line[gp][OFF_W +: SET_W];
         assign pr_tag[gp] = pr_line[gp][OFF_W+SET_W +: TAG_W];
         for (gw = 0; gw < WAYS; gw++) begin : g_vld
            assign pr_vld[gp][gw] = (st_q[pr_set[gp]][gw] != RS_INV);
         end
         rgn_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_probe (
            .way_tag (tag_q[pr_set[gp]]),
            .way_vld (pr_vld[gp]),
            .tag     (pr_tag[gp]),
            .hit     (pr_hit[gp]),
            .way     (pr_way[gp])
         );
      end
   endgenerate

   assign unused_offset_bits = ^pr_off;

   // ---------------- route decision ----------------
   logic [1:0] req_state;
   logic [1:0] req_route;

   assign req_state = pr_hit[P_REQ] ? st_q[pr_set[P_REQ]][pr_way[P_REQ]] : RS_INV;

   rgn_route_decide u_route (
      .kind     (lreq_kind),
      .line_hit (lreq_line_hit),
      .rstate   (req_state),
      .route    (req_route)
   );

   // ---------------- fill / allocation ----------------
   logic             vic_found;
   logic [WAY_W-1:0] vic_way;
   logic             f_alloc;
   logic             f_write;
   logic [WAY_W-1:0] f_way;
   logic [1:0]       f_state;

   rgn_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_victim (
      .way_vld (pr_vld[P_FIL]),
      .way_cnt (cnt_q[pr_set[P_FIL]]),
      .way_age (age_q[pr_set[P_FIL]]),
      .found   (vic_found),
      .way     (vic_way)
   );

   assign f_alloc = fill_valid && !pr_hit[P_FIL] && vic_found;
   assign f_write = fill_valid && (pr_hit[P_FIL] || vic_found);
   assign f_way   = pr_hit[P_FIL] ? pr_way[P_FIL] : vic_way;
   assign f_state = state_from_resp(fill_remote);

   // ---------------- recency touch ----------------
   logic             t_en;
   logic [SET_W-1:0] t_set;
   logic [WAY_W-1:0] t_way;

   always_comb begin
      if (f_write) begin
         t_en  = 1'b1;
         t_set = pr_set[P_FIL];
         t_way = f_way;
      end else begin
         t_en  = lreq_valid && pr_hit[P_REQ];
         t_set = pr_set[P_REQ];
         t_way = pr_way[P_REQ];
      end
   end

   // ---------------- per-entry update ----------------
   generate
      for (gs = 0; gs < SETS; gs++) begin : g_set
         for (gw = 0; gw < WAYS; gw++) begin : g_way
            logic             sel_fill;
            logic             sel_snp;
            logic             inc;
            logic             dec;
            logic [CNT_W-1:0] cnt_nx;
            logic [WAY_W-1:0] age_nx;

            assign sel_fill = f_write && (pr_set[P_FIL] == SET_W'(gs)) && (f_way == WAY_W'(gw));
            assign sel_snp  = snp_valid && pr_hit[P_SNP] &&
                              (pr_set[P_SNP] == SET_W'(gs)) && (pr_way[P_SNP] == WAY_W'(gw));
            assign inc      = lfill_valid && pr_hit[P_LFL] &&
                              (pr_set[P_LFL] == SET_W'(gs)) && (pr_way[P_LFL] == WAY_W'(gw));
            assign dec      = levict_valid && pr_hit[P_LEV] &&
                              (pr_set[P_LEV] == SET_W'(gs)) && (pr_way[P_LEV] == WAY_W'(gw));

            always_comb begin
               cnt_nx = cnt_q[gs][gw];
               if (inc && !dec && (cnt_q[gs][gw] < CNT_W'(LINES_PER_RGN)))
                  cnt_nx = cnt_q[gs][gw] + 1'b1;
               else if (dec && !inc && (cnt_q[gs][gw] != '0))
                  cnt_nx = cnt_q[gs][gw] - 1'b1;
            end

            always_comb begin
               age_nx = age_q[gs][gw];
               if (t_en && (t_set == SET_W'(gs))) begin
                  if (t_way == WAY_W'(gw))
                     age_nx = '0;
                  else if (age_q[gs][gw] < age_q[gs][t_way])
                     age_nx = age_q[gs][gw] + 1'b1;
               end
            end

            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  st_q[gs][gw]  <= RS_INV;
                  tag_q[gs][gw] <= '0;
                  cnt_q[gs][gw] <= '0;
                  age_q[gs][gw] <= WAY_W'(gw);
               end else begin
                  age_q[gs][gw] <= age_nx;
                  if (sel_fill) begin
                     st_q[gs][gw]  <= f_state;
                     tag_q[gs][gw] <= pr_tag[P_FIL];
                     cnt_q[gs][gw] <= f_alloc ? '0 : cnt_nx;
                  end else begin
                     if (sel_snp)
                        st_q[gs][gw] <= state_after_snoop(rstate_e'(st_q[gs][gw]), snp_excl);
                     cnt_q[gs][gw] <= cnt_nx;
                  end
               end
            end
         end
      end
   endgenerate

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_valid     <= 1'b0;
         route_code      <= RT_LOCAL;
         snp_resp_valid  <= 1'b0;
         snp_resp_cached <= 1'b0;
      end else begin
         route_valid     <= lreq_valid;
         route_code      <= lreq_valid ? req_route : RT_LOCAL;
         snp_resp_valid  <= snp_valid;
         snp_resp_cached <= snp_valid && pr_hit[P_SNP] &&
                            (cnt_q[pr_set[P_SNP]][pr_way[P_SNP]] != '0);
      end
   end

endmodule

// File: rtl/rgn_track_array_chk.sv
module rgn_track_array_chk
   import rgn_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       lreq_valid,
   input logic [2:0] lreq_kind,
   input logic       lreq_line_hit,
   input logic       route_valid,
   input logic [1:0] route_code,
   input logic       snp_valid,
   input logic       snp_resp_valid
);

   AST_ROUTE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid |=> route_valid); // R2

   AST_ROUTE_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lreq_valid |=> !route_valid); // R2

   AST_ROUTE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> (route_code != 2'd3)); // R2

   AST_WBACK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_valid && (lreq_kind == K_WBACK)) |=> (route_code == RT_DIRECT)); // R3

   AST_LINE_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_valid && lreq_line_hit && (lreq_kind != K_WBACK)) |=> (route_code == RT_LOCAL)); // R4

   AST_SNP_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |=> snp_resp_valid); // R10

   AST_SNP_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |=> !snp_resp_valid); // R10

endmodule

bind rgn_track_array rgn_track_array_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lreq_valid     (lreq_valid),
   .lreq_kind      (lreq_kind),
   .lreq_line_hit  (lreq_line_hit),
   .route_valid    (route_valid),
   .route_code     (route_code),
   .snp_valid      (snp_valid),
   .snp_resp_valid (snp_resp_valid)
);

// File: tb/rgn_track_array_tb.sv
module rgn_track_array_tb;

   localparam int LAW = 8;
   localparam int LPR = 4;
   localparam int NS  = 2;
   localparam int NW  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           lreq_valid = 1'b0;
   logic [LAW-1:0] lreq_line = '0;
   logic [2:0]     lreq_kind = '0;
   logic           lreq_line_hit = 1'b0;
   logic           route_valid;
   logic [1:0]     route_code;
   logic           snp_valid = 1'b0;
   logic [LAW-1:0] snp_line = '0;
   logic           snp_excl = 1'b0;
   logic           snp_resp_valid;
   logic           snp_resp_cached;
   logic           fill_valid = 1'b0;
   logic [LAW-1:0] fill_line = '0;
   logic [1:0]     fill_remote = '0;
   logic           lfill_valid = 1'b0;
   logic [LAW-1:0] lfill_line = '0;
   logic           levict_valid = 1'b0;
   logic [LAW-1:0] levict_line = '0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   rgn_track_array #(.LINE_AW(LAW), .LINES_PER_RGN(LPR), .SETS(NS), .WAYS(NW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lreq_valid(lreq_valid), .lreq_line(lreq_line), .lreq_kind(lreq_kind),
      .lreq_line_hit(lreq_line_hit),
      .route_valid(route_valid), .route_code(route_code),
      .snp_valid(snp_valid), .snp_line(snp_line), .snp_excl(snp_excl),
      .snp_resp_valid(snp_resp_valid), .snp_resp_cached(snp_resp_cached),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_remote(fill_remote),
      .lfill_valid(lfill_valid), .lfill_line(lfill_line),
      .levict_valid(levict_valid), .levict_line(levict_line)
   );

   // bench state codes: 0 absent, 1 exclusive, 2 clean remote, 3 dirty remote
   function automatic int exp_route(input int st, input int kind, input int hit);
      if (kind == 4) return 1;
      if (hit != 0) return 0;
      if (st == 1) return ((kind == 5) || (kind == 6)) ? 0 : 1;
      if (st == 2) return (kind == 3) ? 1 : 2;
      return 2;
   endfunction

   function automatic int exp_after_snoop(input int st, input int ex);
      if (st == 1) return (ex != 0) ? 3 : 2;
      if (st == 2) return (ex != 0) ? 3 : 2;
      return st;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      lreq_valid = 1'b0; snp_valid = 1'b0; fill_valid = 1'b0;
      lfill_valid = 1'b0; levict_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic chk_route(input int rgn, input int off, input int kind, input int hit,
                            input int exp, input string req);
      @(negedge clk);
      lreq_valid = 1'b1; lreq_line = LAW'(rgn * LPR + off);
      lreq_kind = 3'(kind); lreq_line_hit = (hit != 0);
      @(negedge clk);
      lreq_valid = 1'b0;
      check(req, {29'd0, route_valid, route_code}, 4 + exp, "route {valid,code}");
   endtask

   task automatic do_fill(input int rgn, input int remote);
      @(negedge clk);
      fill_valid = 1'b1; fill_line = LAW'(rgn * LPR); fill_remote = 2'(remote);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_lfill(input int rgn, input int off);
      @(negedge clk);
      lfill_valid = 1'b1; lfill_line = LAW'(rgn * LPR + off);
      @(negedge clk);
      lfill_valid = 1'b0;
   endtask

   task automatic do_levict(input int rgn, input int off);
      @(negedge clk);
      levict_valid = 1'b1; levict_line = LAW'(rgn * LPR + off);
      @(negedge clk);
      levict_valid = 1'b0;
   endtask

   task automatic chk_snoop(input int rgn, input int ex, input int exp_cached, input string req);
      @(negedge clk);
      snp_valid = 1'b1; snp_line = LAW'(rgn * LPR + 1); snp_excl = (ex != 0);
      @(negedge clk);
      snp_valid = 1'b0;
      check(req, {30'd0, snp_resp_valid, snp_resp_cached}, 2 + exp_cached, "snoop {valid,cached}");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // reset state
      do_reset();
      check("R2", {31'd0, route_valid}, 0, "route_valid after reset");
      check("R10", {31'd0, snp_resp_valid}, 0, "snp_resp_valid after reset");
      chk_route(3, 0, 0, 0, 2, "R5");

      // full routing sweep: every state, kind, hit value and line offset (R1 R3..R8)
      for (int st = 0; st < 4; st++) begin
         do_reset();
         if (st > 0) do_fill(5, st - 1);
         for (int kind = 0; kind < 7; kind++)
            for (int hit = 0; hit < 2; hit++)
               for (int off = 0; off < LPR; off++)
                  chk_route(5, off, kind, hit, exp_route(st, kind, hit),
                            (kind == 4) ? "R3" : (hit != 0) ? "R4" :
                            (st == 0) ? "R5" : (st == 1) ? ((kind >= 5) ? "R7" : "R6") : "R8");
         // a neighbouring region in the same set is not covered by that entry (R1)
         chk_route(7, 2, 0, 0, 2, "R1");
      end
      // fill code 3 counts as possibly modified
      do_reset();
      do_fill(5, 3);
      chk_route(5, 0, 3, 0, 2, "R8");

      // snoop downgrade sweep (R9)
      for (int r = 0; r < 3; r++)
         for (int ex = 0; ex < 2; ex++) begin
            do_reset();
            do_fill(5, r);
            chk_snoop(5, ex, 0, "R9");
            chk_route(5, 0, 0, 0, exp_route(exp_after_snoop(r + 1, ex), 0, 0), "R9");
            chk_route(5, 1, 3, 0, exp_route(exp_after_snoop(r + 1, ex), 3, 0), "R9");
         end
      do_reset();
      chk_snoop(6, 0, 0, "R9");
      chk_route(6, 0, 0, 0, 2, "R9");

      // line counts and snoop status (R10 R11)
      do_reset();
      do_fill(5, 0);
      chk_snoop(5, 0, 0, "R10");
      do_lfill(5, 1);
      chk_snoop(5, 0, 1, "R10");
      do_levict(5, 1);
      chk_snoop(5, 0, 0, "R11");
      do_levict(5, 2);
      do_lfill(5, 0);
      chk_snoop(5, 0, 1, "R11");
      do_levict(5, 0);
      for (int i = 0; i < LPR + 2; i++) do_lfill(5, i % LPR);
      for (int i = 0; i < LPR; i++) do_levict(5, i);
      chk_snoop(5, 0, 0, "R11");
      do_lfill(6, 0);
      do_fill(6, 0);
      chk_snoop(6, 0, 0, "R11");

      // replacement (R12); regions 0, 2, 4 share set 0
      do_reset();
      do_fill(0, 0);
      do_fill(4, 0);
      chk_route(0, 0, 0, 0, 1, "R12");
      chk_route(4, 0, 0, 0, 1, "R12");

      do_reset();
      do_fill(0, 0);
      do_fill(2, 0);
      chk_route(0, 1, 0, 0, 1, "R12");
      do_fill(4, 0);
      chk_route(4, 0, 0, 0, 1, "R12");
      chk_route(0, 0, 0, 0, 1, "R12");
      chk_route(2, 0, 0, 0, 2, "R12");

      do_reset();
      do_fill(0, 0);
      do_fill(2, 0);
      do_lfill(0, 0);
      do_lfill(2, 0);
      do_fill(4, 0);
      chk_route(4, 0, 0, 0, 2, "R12");
      chk_route(0, 0, 0, 0, 1, "R12");
      chk_route(2, 0, 0, 0, 1, "R12");

      do_reset();
      do_fill(0, 0);
      do_fill(2, 0);
      do_lfill(0, 3);
      chk_route(2, 0, 0, 0, 1, "R12");
      do_fill(4, 0);
      chk_route(4, 0, 0, 0, 1, "R12");
      chk_route(0, 0, 0, 0, 1, "R12");
      chk_route(2, 0, 0, 0, 2, "R12");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule